// File: doc/BRIEF.md
# Dual-Channel DAC Code Sequencer

This block is the digital control side of a two-channel, 8-bit digital-to-analog converter. A bus master writes through a single-cycle write port to three registers: one code register for each channel and one control register that holds an output-enable bit for each channel. Each channel keeps its own conversion timer. When a channel's enable bit goes from 0 to 1, its timer starts. A new code written to an enabled channel aborts the conversion in progress and starts the timer again. When the timer expires, the channel presents the code on its output and raises its drive flag.

While a channel's drive flag is low, the analog buffer it controls is meant to be in the high-impedance state. The ideal analog level is code/256 of the reference, so code 0 maps to zero and there are 256 steps. The analog stage is not part of this block. The block supplies only the held code, the conversion timing and the drive control.

Top module: `dac_ctrl`

## Requirements
- R1: After reset, all three registers read zero, both drive flags are low and both code outputs are zero.
- R2: Register offsets are 0 for the channel 0 code, 1 for the channel 1 code and 2 for control. Control bit 0 enables channel 0 and bit 1 enables channel 1. Each register reads back its last written value. Control bits 7:2 always read zero. A write to offset 3 is ignored, and offset 3 reads zero.
- R3: A control write that sets an enable bit which was clear starts a conversion on that channel. Its drive flag rises exactly CONV_CYCLES clock edges after the write edge, and the code output then carries the register contents.
- R4: A code write to an enabled channel restarts its conversion. Until the new conversion completes, the output keeps the previously presented code and its drive state. The new code appears exactly CONV_CYCLES edges after the write edge.
- R5: A code write to a disabled channel only stores the value. The drive flag stays low, and the stored value is the one converted at the next enable.
- R6: A control write that clears an enable bit drops that channel's drive flag and zeroes its code output at the write edge, and it aborts any pending conversion.
- R7: A control write that leaves an already-set enable bit set neither restarts nor delays that channel's conversion.
- R8: The two channels run independently. A write aimed at one channel never changes the timing or output of the other.
- R9: Once valid, a channel's output holds steady until its code register is rewritten or it is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register offset |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| dac_code | output | 16 | Presented codes, channel 0 in bits 7:0 and channel 1 in bits 15:8 |
| dac_drive | output | 2 | Per-channel drive flag, 0 means high impedance |

## Verification
The bench measures the conversion latency to the exact edge, one cycle before and at the expected completion. An off-by-one timer therefore shows up as a flag that rises early or late. It rewrites a running channel and checks that the old code stays on the output for the whole restart window. A design that blanked the output, or passed the new code straight through, would fail that check. It rewrites the control register with an enable still set in the middle of a conversion, which catches a design that restarts on every control write rather than only on a 0-to-1 change. It also disables a channel partway through a conversion and waits past the completion point, which exposes a timer that is not aborted and raises the drive flag on a channel that is switched off.

// File: rtl/dac_pkg.sv
package dac_pkg;
    localparam int unsigned DAC_DW  = 8;
    localparam int unsigned DAC_NCH = 2;

    typedef logic [DAC_DW-1:0] dac_code_t;
endpackage

// File: rtl/dac_regfile.sv
module dac_regfile #(
    parameter int unsigned NCH = 2,
    parameter int unsigned DW  = 8,
    parameter int unsigned AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [NCH*DW-1:0] code_reg,
    output logic [NCH-1:0]    start,
    output logic [NCH-1:0]    stop
);
    localparam int unsigned CTRL_OFS = NCH;

    typedef struct packed {
        logic [NCH*DW-1:0] code;
        logic [NCH-1:0]    en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_wr;

    always_comb begin
        regs_d  = regs_q;
        start   = '0;
        stop    = '0;
        ctrl_wr = wr_en && (int'(wr_addr) == CTRL_OFS);
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && (int'(wr_addr) == i)) begin
                regs_d.code[i*DW +: DW] = wr_data;
                start[i] = regs_q.en[i];
            end
            if (ctrl_wr) begin
                regs_d.en[i] = wr_data[i];
                if (wr_data[i] && !regs_q.en[i]) start[i] = 1'b1;
                if (!wr_data[i])                 stop[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(rd_addr) == i) rd_data = regs_q.code[i*DW +: DW];
        end
        if (int'(rd_addr) == CTRL_OFS) rd_data[NCH-1:0] = regs_q.en;
    end

    assign code_reg = regs_q.code;
endmodule

// File: rtl/dac_conv_chan.sv
module dac_conv_chan #(
    parameter int unsigned DW          = 8,
    parameter int unsigned CONV_CYCLES = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [DW-1:0] code_in,
    output logic [DW-1:0] code_out,
    output logic          drive
);
    localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CONV_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] code;
        logic          drive;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d = '0;
        end else if (start) begin
            st_d.cnt = RELOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.code  = code_in;
                st_d.drive = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_out = st_q.code;
    assign drive    = st_q.drive;
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl #(
    parameter int unsigned NCH         = dac_pkg::DAC_NCH,
    parameter int unsigned DW          = dac_pkg::DAC_DW,
    parameter int unsigned AW          = 2,
    parameter int unsigned CONV_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH-1:0]    dac_drive
);
    logic [NCH*DW-1:0] code_reg;
    logic [NCH-1:0]    start;
    logic [NCH-1:0]    stop;

    dac_regfile #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .code_reg (code_reg),
        .start    (start),
        .stop     (stop)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dac_conv_chan #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start[g]),
            .stop     (stop[g]),
            .code_in  (code_reg[g*DW +: DW]),
            .code_out (dac_code[g*DW +: DW]),
            .drive    (dac_drive[g])
        );
    end
endmodule

// File: rtl/dac_ctrl_sva.sv
module dac_ctrl_sva #(
    parameter int unsigned NCH         = 2,
    parameter int unsigned DW          = 8,
    parameter int unsigned AW          = 2,
    parameter int unsigned CONV_CYCLES = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [AW-1:0]     rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic [NCH*DW-1:0] dac_code,
    input logic [NCH-1:0]    dac_drive
);
    localparam int unsigned SW = $clog2(CONV_CYCLES + 2);
    localparam logic [SW-1:0] SAT  = SW'(CONV_CYCLES + 1);
    localparam logic [SW-1:0] DONE = SW'(CONV_CYCLES);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (int'(wr_addr) == NCH);

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) == NCH) |-> (rd_data[DW-1:NCH] == '0)); // R2

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic          en_sh;
        logic [SW-1:0] since;
        logic          kick;

        assign kick = (ctrl_wr && wr_data[g] && !en_sh) ||
                      (wr_en && (int'(wr_addr) == g) && en_sh);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_sh <= 1'b0;
                since <= SAT;
            end else begin
                if (ctrl_wr) en_sh <= wr_data[g];
                if (kick)              since <= '0;
                else if (since != SAT) since <= since + 1'b1;
            end
        end

        AST_RISE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dac_drive[g]) |-> (since == DONE)); // R3

        AST_SWAP_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
            (dac_drive[g] && $past(dac_drive[g]) && since != DONE)
                |-> $stable(dac_code[g*DW +: DW])); // R4

        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !en_sh |-> (!dac_drive[g] && dac_code[g*DW +: DW] == '0)); // R6

        AST_DROP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && !wr_data[g]) |=> !dac_drive[g]); // R6
    end
endmodule

bind dac_ctrl dac_ctrl_sva #(
    .NCH(NCH), .DW(DW), .AW(AW), .CONV_CYCLES(CONV_CYCLES)
) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dac_code(dac_code), .dac_drive(dac_drive)
);

// File: tb/tb_dac_ctrl.sv
`timescale 1ns/1ps
module tb_dac_ctrl;
    localparam int CONV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] dac_code;
    logic [1:0]  dac_drive;

    int checks = 0;
    int errors = 0;

    dac_ctrl #(.CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dac_code(dac_code), .dac_drive(dac_drive)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        rd_addr = a; #1;
        chk(req, "readback", int'(rd_data), exp);
    endtask

    task automatic out_chk(input string req, input int ch, input int drv, input int code);
        chk(req, $sformatf("ch%0d drive", ch), int'(dac_drive[ch]), drv);
        chk(req, $sformatf("ch%0d code", ch), int'(dac_code[ch*8 +: 8]), code);
    endtask

    task automatic t_reset;
        rd_chk("R1", 2'd0, 0); rd_chk("R1", 2'd1, 0); rd_chk("R1", 2'd2, 0);
        out_chk("R1", 0, 0, 0); out_chk("R1", 1, 0, 0);
    endtask

    task automatic t_regmap;
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd3, 8'hFF);
        rd_chk("R2", 2'd0, 8'hA5); rd_chk("R2", 2'd1, 8'h3C);
        rd_chk("R2", 2'd3, 0); rd_chk("R2", 2'd2, 0);
        out_chk("R5", 0, 0, 0); out_chk("R5", 1, 0, 0);
        wr(2'd2, 8'hFC);
        rd_chk("R2", 2'd2, 0);
        out_chk("R5", 0, 0, 0);
    endtask

    task automatic t_enable_latency;
        wr(2'd0, 8'h5A);
        wr(2'd2, 8'h01);
        idle(CONV - 1);
        out_chk("R3", 0, 0, 0);
        idle(1);
        out_chk("R3", 0, 1, 8'h5A);
        out_chk("R8", 1, 0, 0);
        idle(5);
        out_chk("R9", 0, 1, 8'h5A);
    endtask

    task automatic t_restart;
        wr(2'd0, 8'hC3);
        out_chk("R4", 0, 1, 8'h5A);
        idle(CONV - 1);
        out_chk("R4", 0, 1, 8'h5A);
        idle(1);
        out_chk("R4", 0, 1, 8'hC3);
        rd_chk("R4", 2'd0, 8'hC3);
    endtask

    task automatic t_disable_abort;
        wr(2'd2, 8'h00);
        out_chk("R6", 0, 0, 0);
        wr(2'd0, 8'h11);
        idle(CONV + 2);
        out_chk("R5", 0, 0, 0);
        wr(2'd2, 8'h01);
        idle(3);
        wr(2'd2, 8'h00);
        out_chk("R6", 0, 0, 0);
        idle(CONV + 2);
        out_chk("R6", 0, 0, 0);
    endtask

    task automatic t_hold_enable;
        wr(2'd1, 8'h77);
        wr(2'd2, 8'h01);
        idle(3);
        wr(2'd2, 8'h03);
        idle(5);
        out_chk("R7", 0, 0, 0);
        idle(1);
        out_chk("R7", 0, 1, 8'h11);
        out_chk("R8", 1, 0, 0);
        idle(3);
        out_chk("R8", 1, 0, 0);
        idle(1);
        out_chk("R8", 1, 1, 8'h77);
        wr(2'd2, 8'h02);
        out_chk("R8", 0, 0, 0);
        out_chk("R8", 1, 1, 8'h77);
        rd_chk("R2", 2'd2, 2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_enable_latency();
        t_restart();
        t_disable_abort();
        t_hold_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule